// File: doc/BRIEF.md
# Hardware Mutex Register Bank

This block is a bank of hardware mutex bits shared by several bus masters, for instance a group of application cores and a small management core. Each mutex has its own 32-bit register. A master takes a mutex by reading its register. A returned 0 means the mutex was free and now belongs to the caller. A returned 1 means another holder has it and the caller must try again. The holder frees the mutex by writing zero to the same register. The block does not record who holds a mutex, so a holder that reads its own mutex a second time is refused.

Two fixed words sit below the mutex registers. A configuration word reports the size of the bank as a code. A status word shows the state of the first 32 mutexes, and reading it changes nothing.

Each master has its own request port. Every port is served in every cycle, and each port gets its response one cycle after its request. When several ports touch the bank in the same cycle, their accesses take effect in fixed priority order, lowest port index first. Each access sees the result of the accesses ranked ahead of it.

Top module: `hw_mutex_bank`

## Requirements
- R1: A read of the register of a free mutex returns 0 and marks that mutex taken in the same access.
- R2: A read of the register of a taken mutex returns 1 and leaves it taken, even when the reader is the one that took it.
- R3: Writing 0 to a mutex register frees that mutex. Writing any non-zero value to it has no effect.
- R4: The word at address 0x000 reads as a size code in bits 31:28, with all other bits zero. The code is 1 for 32 mutexes, 2 for 64, 3 for 128 and 4 for 256. Writes to this word have no effect.
- R5: The word at address 0x010 reads with bit n equal to the state of mutex n (1 = taken) for n from 0 to 31. Mutexes above 31 have no bit there, and reading the word changes no mutex.
- R6: Mutex n is at byte address 0x100 + 4·n. An address past the last mutex reads 0, and neither a read nor a write there has any effect.
- R7: Accesses made in the same cycle take effect in order of port index, lowest first. Of several simultaneous reads of one free mutex, only the lowest-index port gets 0. Each port's result includes the effect of the lower-index ports in that cycle, including a release by a lower-index port.
- R8: Every accepted request raises that port's rsp_valid exactly one cycle later. An idle port's rsp_valid stays low. Mutex reads return data with bits 31:1 zero, and writes return 0.
- R9: Reset frees every mutex and clears rsp_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_PORTS | Per-port request strobe |
| req_write | input | NUM_PORTS | Per-port write (1) or read (0) |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port byte address, port p in slice p |
| req_wdata | input | NUM_PORTS*32 | Per-port write data |
| rsp_valid | output | NUM_PORTS | Per-port response strobe, one cycle after the request |
| rsp_rdata | output | NUM_PORTS*32 | Per-port read data |

## Verification
A table of two-port vectors covers the following cases:
- single takes, and repeated takes by the same holder;
- non-zero and zero writes, with status reads in between, so that a dropped release can be told apart from a release triggered by any write;
- both ports reading one free mutex at once, which separates correct priority from a double grant;
- a release and a take of one mutex in the same cycle, in both port orders, which shows whether the later port sees the earlier port's effect;
- a take and a status read in the same cycle.

Directed steps then check the size code, the effect of an out-of-range address, and reset while mutexes are held. A 256-mutex instance checks that the highest mutex is placed correctly and that it has no status bit.

// File: rtl/hw_mutex_bank.sv
module hw_mutex_bank #(
  parameter int NUM_LOCKS = 32,
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        req_valid,
  input  logic [NUM_PORTS-1:0]        req_write,
  input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
  input  logic [NUM_PORTS*32-1:0]     req_wdata,
  output logic [NUM_PORTS-1:0]        rsp_valid,
  output logic [NUM_PORTS*32-1:0]     rsp_rdata
);

  localparam int IDX_W = $clog2(NUM_LOCKS);
  localparam logic [3:0] SIZE_CODE = 4'($clog2(NUM_LOCKS) - 4);
  localparam logic [ADDR_W-1:0] CFG_ADDR   = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] LOCK_BASE  = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] LOCK_LIMIT = ADDR_W'(NUM_LOCKS);

  logic [NUM_LOCKS-1:0] lock_q, lock_nx;

  logic [ADDR_W-1:0] p_addr [NUM_PORTS];
  logic [ADDR_W-1:0] p_off  [NUM_PORTS];
  logic [31:0]       p_wd   [NUM_PORTS];
  logic [IDX_W-1:0]  p_idx  [NUM_PORTS];
  logic [NUM_PORTS-1:0] p_hit, p_cfg, p_stat;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign p_addr[p] = {req_addr[p*ADDR_W+2 +: ADDR_W-2], 2'b00};
    assign p_wd[p]   = req_wdata[p*32 +: 32];
    assign p_off[p]  = p_addr[p] - LOCK_BASE;
    assign p_idx[p]  = p_off[p][IDX_W+1:2];
    assign p_hit[p]  = (p_addr[p] >= LOCK_BASE) && ({2'b00, p_off[p][ADDR_W-1:2]} < LOCK_LIMIT);
    assign p_cfg[p]  = p_addr[p] == CFG_ADDR;
    assign p_stat[p] = p_addr[p] == STAT_ADDR;
  end

  logic [31:0]          rd_c    [NUM_PORTS];
  logic [NUM_PORTS-1:0] grant_c;
  logic                 take_c, rel_c;

  always_comb begin
    lock_nx = lock_q;
    grant_c = '0;
    take_c  = 1'b0;
    rel_c   = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      rd_c[p] = '0;
      if (req_valid[p]) begin
        if (req_write[p]) begin
          if (p_hit[p] && p_wd[p] == 32'h0) begin
            lock_nx[p_idx[p]] = 1'b0;
            rel_c = 1'b1;
          end
        end else if (p_hit[p]) begin
          rd_c[p]    = {31'h0, lock_nx[p_idx[p]]};
          grant_c[p] = !lock_nx[p_idx[p]];
          lock_nx[p_idx[p]] = 1'b1;
          take_c = 1'b1;
        end else if (p_cfg[p]) begin
          rd_c[p] = {SIZE_CODE, 28'h0};
        end else if (p_stat[p]) begin
          rd_c[p] = lock_nx[31:0];
        end
      end
    end
  end

  logic [NUM_PORTS-1:0] grant_q;
  logic [IDX_W-1:0]     gidx_q [NUM_PORTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= '0;
      rsp_valid <= '0;
      rsp_rdata <= '0;
      grant_q   <= '0;
      for (int p = 0; p < NUM_PORTS; p++) gidx_q[p] <= '0;
    end else begin
      lock_q    <= lock_nx;
      rsp_valid <= req_valid;
      grant_q   <= grant_c;
      for (int p = 0; p < NUM_PORTS; p++) begin
        rsp_rdata[p*32 +: 32] <= rd_c[p];
        gidx_q[p] <= p_idx[p];
      end
    end
  end

  assert_take_needs_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !take_c |=> (lock_q & ~$past(lock_q)) == '0);

  assert_release_needs_zero_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_c |=> ($past(lock_q) & ~lock_q) == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] |=> rsp_valid[p]);
    assert_idle_no_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[p] |=> !rsp_valid[p]);
    assert_grant_is_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q[p] |-> rsp_rdata[p*32 +: 32] == 32'h0);
    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
      assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q[p] && grant_q[q]) |-> gidx_q[p] != gidx_q[q]);
    end
  end

endmodule

// File: tb/test_hw_mutex_bank.sv
`timescale 1ns/1ps
module test_hw_mutex_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  req_valid = '0, req_write = '0, rsp_valid;
  logic [23:0] req_addr = '0;
  logic [63:0] req_wdata = '0, rsp_rdata;

  logic        b_valid = 1'b0, b_write = 1'b0, b_rv;
  logic [11:0] b_addr = '0;
  logic [31:0] b_wdata = '0, b_rd;

  hw_mutex_bank #(.NUM_LOCKS(32), .NUM_PORTS(2), .ADDR_W(12)) i_hw_mutex_bank (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .rsp_valid, .rsp_rdata);

  hw_mutex_bank #(.NUM_LOCKS(256), .NUM_PORTS(1), .ADDR_W(12)) i_hw_mutex_bank_256 (
    .clk, .rst_n, .req_valid(b_valid), .req_write(b_write), .req_addr(b_addr),
    .req_wdata(b_wdata), .rsp_valid(b_rv), .rsp_rdata(b_rd));

  int checks = 0, errors = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // fields: v0 w0 a0 d0 | v1 w1 a1 d1 | exp0 exp1
  localparam int NV = 13;
  localparam logic [155:0] VEC [NV] = '{
    {1'b1,1'b0,12'h000,32'h0, 1'b1,1'b0,12'h010,32'h0, 32'h1000_0000, 32'h0},
    {1'b1,1'b0,12'h100,32'h0, 1'b0,1'b0,12'h000,32'h0, 32'h0, 32'h0},
    {1'b1,1'b0,12'h100,32'h0, 1'b0,1'b0,12'h000,32'h0, 32'h1, 32'h0},
    {1'b0,1'b0,12'h000,32'h0, 1'b1,1'b0,12'h010,32'h0, 32'h0, 32'h1},
    {1'b1,1'b1,12'h100,32'h5, 1'b1,1'b0,12'h100,32'h0, 32'h0, 32'h1},
    {1'b1,1'b1,12'h100,32'h0, 1'b1,1'b0,12'h010,32'h0, 32'h0, 32'h0},
    {1'b1,1'b0,12'h17C,32'h0, 1'b1,1'b0,12'h17C,32'h0, 32'h0, 32'h1},
    {1'b1,1'b0,12'h104,32'h0, 1'b1,1'b0,12'h010,32'h0, 32'h0, 32'h8000_0002},
    {1'b1,1'b1,12'h17C,32'h0, 1'b1,1'b0,12'h17C,32'h0, 32'h0, 32'h0},
    {1'b1,1'b0,12'h17C,32'h0, 1'b1,1'b1,12'h17C,32'h0, 32'h1, 32'h0},
    {1'b1,1'b0,12'h180,32'h0, 1'b1,1'b0,12'h010,32'h0, 32'h0, 32'h2},
    {1'b1,1'b1,12'h000,32'h0, 1'b1,1'b0,12'h000,32'h0, 32'h0, 32'h1000_0000},
    {1'b1,1'b0,12'h010,32'h0, 1'b0,1'b0,12'h000,32'h0, 32'h2, 32'h0}
  };
  localparam string TAG [NV] = '{"R4", "R1", "R2", "R5", "R3", "R7", "R7", "R7",
                                  "R7", "R7", "R6", "R4", "R6"};

  task automatic bank_op(logic w, logic [11:0] a, logic [31:0] d);
    b_valid = 1'b1; b_write = w; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset rsp_valid", {30'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      req_valid = {VEC[i][109], VEC[i][155]};
      req_write = {VEC[i][108], VEC[i][154]};
      req_addr  = {VEC[i][107:96], VEC[i][153:142]};
      req_wdata = {VEC[i][95:64], VEC[i][141:110]};
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
        if (req_valid[p]) begin
          check($sformatf("%s vec%0d port%0d valid", TAG[i], i, p), {31'h0, rsp_valid[p]}, 32'h1);
          check($sformatf("%s vec%0d port%0d data", TAG[i], i, p), rsp_rdata[p*32 +: 32],
                p == 0 ? VEC[i][63:32] : VEC[i][31:0]);
        end else begin
          check($sformatf("R8 vec%0d idle port%0d", i, p), {31'h0, rsp_valid[p]}, 32'h0);
        end
      end
    end
    req_valid = '0;

    // mutex 1 is still held; take mutex 2 as well, then reset
    req_valid = 2'b01; req_write = 2'b00; req_addr = {12'h000, 12'h108};
    @(negedge clk);
    check("R1 take mutex 2", rsp_rdata[31:0], 32'h0);
    req_valid = '0;
    rst_n = 1'b0;
    #1;
    check("R9 rsp_valid cleared", {30'h0, rsp_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req_valid = 2'b10; req_addr = {12'h010, 12'h000};
    @(negedge clk);
    check("R9 all free after reset", rsp_rdata[63:32], 32'h0);
    req_valid = '0;

    // 256-mutex instance
    bank_op(1'b0, 12'h000, 32'h0);
    check("R4 code for 256", b_rd, 32'h4000_0000);
    bank_op(1'b0, 12'h4FC, 32'h0);
    check("R6 top mutex take", b_rd, 32'h0);
    bank_op(1'b0, 12'h4FC, 32'h0);
    check("R2 top mutex held", b_rd, 32'h1);
    bank_op(1'b0, 12'h010, 32'h0);
    check("R5 no status bit above 31", b_rd, 32'h0);
    bank_op(1'b0, 12'h500, 32'h0);
    check("R6 past last mutex", b_rd, 32'h0);
    bank_op(1'b1, 12'h4FC, 32'h0);
    bank_op(1'b0, 12'h4FC, 32'h0);
    check("R3 top mutex released", b_rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule